// File: doc/BRIEF.md
# DRAM Command Spacing Monitor

This block sits beside a memory controller and observes every command the controller issues to a single synchronous DRAM device. For each command it decides, from the bank state and from the elapsed clock counts it keeps, whether the command came too early after an earlier one. It also checks whether a row has been left open too long. Every broken rule raises its own one-clock violation bit. The lowest-numbered broken rule is reported as a code, and each rule owns a sticky bit that stays set until software-like logic clears it with a write-one-to-clear vector.

All spacing limits are parameters given in clock counts. Each one is the nanosecond minimum divided by the clock period and rounded up. Two limits are derived inside the block rather than supplied. The write activate-to-column delay is the read delay minus two clocks, but never less than two. The auto-precharge write recovery is a fixed five clocks, and it is added to the precharge time to form the activate spacing that applies after a write with auto-precharge.

Top module: `dram_cmd_timing_mon`

## Requirements
- R1: Commands are encoded on `cmd_i` as activate=0, read=1, write=2, precharge=3, write with auto-precharge=4, refresh=5, mode set=6, self-refresh exit=7. The STATE rule (bit 0) fires for a read, write or auto-precharge write to a closed bank, for an activate to an open bank, and for a refresh while any bank is open.
- R2: The RRD rule (bit 1) fires for an activate to a bank other than the most recently activated one, issued fewer than T_RRD clocks after that activate.
- R3: The RC rule (bit 2) fires for an activate issued fewer than T_RC clocks after the previous activate of the same bank.
- R4: The RP rule (bit 3) fires for an activate issued fewer than T_RP clocks after a precharge that closed the same bank. A precharge to a closed bank changes nothing.
- R5: The RCD rule (bit 4) fires for a read to an open bank issued fewer than T_RCD_RD clocks after its activate. It also fires for a write or auto-precharge write issued fewer than max(T_RCD_RD-2, 2) clocks after the activate.
- R6: The RAS_MIN rule (bit 5) fires for a precharge to an open bank issued fewer than T_RAS clocks after its activate.
- R7: The RAS_MAX rule (bit 6) fires once when a bank is still open and no precharge or auto-precharge write reaches it in the clock its activate becomes T_RAS_MAX clocks old.
- R8: The DAL rule (bit 7) fires for an activate to a bank whose last column command was an auto-precharge write, when fewer than BURST_CLK + 5 + T_RP clocks have passed since that write command. Write data ends BURST_CLK clocks after the command.
- R9: The CDLR rule (bit 8) fires for a read issued fewer than BURST_CLK + T_CDLR clocks after any write or auto-precharge write.
- R10: The RFC rule (bit 9) fires for any command issued fewer than T_RFC clocks after a refresh. The MRD rule (bit 10) fires for any command issued fewer than T_MRD clocks after a mode set.
- R11: The XSR rule (bit 11) fires for a read issued fewer than T_XSR clocks after a self-refresh exit.
- R12: Violation bits appear on `viol_o` for exactly one clock, in the clock after the offending command. `viol_any_o` is their OR. `viol_code_o` is the lowest set bit index, or 0 when none is set. Without a command only bit 6 can fire.
- R13: `sticky_o` bit i is set by violation i and cleared by `clr_i` bit i. A violation in the same clock as its clear wins.
- R14: After reset no violation is reported, all sticky bits are 0, and every timer counts as long expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is issued in this clock |
| cmd_i | input | 3 | Command code (see R1) |
| bank_i | input | $clog2(NUM_BANKS) | Target bank |
| clr_i | input | 12 | Write-one-to-clear for the sticky bits |
| viol_o | output | 12 | One-clock violation bit per rule |
| viol_any_o | output | 1 | Any violation this clock |
| viol_code_o | output | 4 | Lowest violated rule index |
| sticky_o | output | 12 | Sticky violation bits |

## Verification
The assertions check four things on every clock: the refresh and mode-set windows against counters kept in the checker, the agreement between the code and the violation vector, the rule that only the open-row limit may fire without a command, and the set and hold behaviour of the sticky bits. The per-bank rules need the bank state and the write history, and the derived write delay and auto-precharge spacing need exact counts at the boundary. Only the bench's scenarios show these, by comparing against a behavioural model on every clock. That includes the legal cases one clock past each limit.

// File: rtl/dram_mon_pkg.sv
package dram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_WRA = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_SRX = 3'd7
    } dram_cmd_e;

    localparam int NUM_RULES    = 12;
    localparam int RULE_W       = 4;

    // Bit positions double as priority: the lowest index is reported first.
    localparam int RULE_STATE   = 0;
    localparam int RULE_RRD     = 1;
    localparam int RULE_RC      = 2;
    localparam int RULE_RP      = 3;
    localparam int RULE_RCD     = 4;
    localparam int RULE_RAS_MIN = 5;
    localparam int RULE_RAS_MAX = 6;
    localparam int RULE_DAL     = 7;
    localparam int RULE_CDLR    = 8;
    localparam int RULE_RFC     = 9;
    localparam int RULE_MRD     = 10;
    localparam int RULE_XSR     = 11;

    // Auto-precharge write recovery does not scale with the clock period.
    localparam int T_WR_AUTO    = 5;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_mon_bank.sv
module dram_mon_bank
    import dram_mon_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int T_RAS_MAX = 34966
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hit_i,
    input  dram_cmd_e        cmd_i,
    output logic             active_o,
    output logic             ap_pend_o,
    output logic [CNT_W-1:0] act_age_o,
    output logic [CNT_W-1:0] pre_age_o,
    output logic [CNT_W-1:0] wr_age_o,
    output logic             ras_over_o
);

    localparam logic [CNT_W-1:0] AGE_ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] AGE_RAS_MAX = CNT_W'(T_RAS_MAX);

    typedef struct packed {
        logic             active;
        logic             ap_pend;
        logic [CNT_W-1:0] act_age;
        logic [CNT_W-1:0] pre_age;
        logic [CNT_W-1:0] wr_age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] age_inc(input logic [CNT_W-1:0] a);
        return (a == '1) ? a : a + AGE_ONE;
    endfunction

    always_comb begin
        st_d         = st_q;
        st_d.act_age = age_inc(st_q.act_age);
        st_d.pre_age = age_inc(st_q.pre_age);
        st_d.wr_age  = age_inc(st_q.wr_age);
        if (hit_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    st_d.active  = 1'b1;
                    st_d.ap_pend = 1'b0;
                    st_d.act_age = AGE_ONE;
                end
                CMD_PRE: begin
                    if (st_q.active) begin
                        st_d.active  = 1'b0;
                        st_d.pre_age = AGE_ONE;
                    end
                end
                CMD_WR: begin
                    st_d.wr_age = AGE_ONE;
                end
                CMD_WRA: begin
                    st_d.wr_age  = AGE_ONE;
                    st_d.active  = 1'b0;
                    st_d.ap_pend = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.active  <= 1'b0;
            st_q.ap_pend <= 1'b0;
            st_q.act_age <= '1;
            st_q.pre_age <= '1;
            st_q.wr_age  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o   = st_q.active;
    assign ap_pend_o  = st_q.ap_pend;
    assign act_age_o  = st_q.act_age;
    assign pre_age_o  = st_q.pre_age;
    assign wr_age_o   = st_q.wr_age;
    assign ras_over_o = st_q.active && (st_q.act_age == AGE_RAS_MAX)
                        && !(hit_i && ((cmd_i == CMD_PRE) || (cmd_i == CMD_WRA)));

endmodule

// File: rtl/dram_mon_dev.sv
module dram_mon_dev
    import dram_mon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  dram_cmd_e         cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [CNT_W-1:0]  act_age_o,
    output logic [BANK_W-1:0] act_bank_o,
    output logic [CNT_W-1:0]  ref_age_o,
    output logic [CNT_W-1:0]  mrs_age_o,
    output logic [CNT_W-1:0]  srx_age_o,
    output logic [CNT_W-1:0]  wr_age_o
);

    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  act_age;
        logic [BANK_W-1:0] act_bank;
        logic [CNT_W-1:0]  ref_age;
        logic [CNT_W-1:0]  mrs_age;
        logic [CNT_W-1:0]  srx_age;
        logic [CNT_W-1:0]  wr_age;
    } dev_st_t;

    dev_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] age_inc(input logic [CNT_W-1:0] a);
        return (a == '1) ? a : a + AGE_ONE;
    endfunction

    always_comb begin
        st_d         = st_q;
        st_d.act_age = age_inc(st_q.act_age);
        st_d.ref_age = age_inc(st_q.ref_age);
        st_d.mrs_age = age_inc(st_q.mrs_age);
        st_d.srx_age = age_inc(st_q.srx_age);
        st_d.wr_age  = age_inc(st_q.wr_age);
        if (cmd_valid_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    st_d.act_age  = AGE_ONE;
                    st_d.act_bank = bank_i;
                end
                CMD_WR, CMD_WRA: st_d.wr_age  = AGE_ONE;
                CMD_REF:         st_d.ref_age = AGE_ONE;
                CMD_MRS:         st_d.mrs_age = AGE_ONE;
                CMD_SRX:         st_d.srx_age = AGE_ONE;
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.act_age  <= '1;
            st_q.act_bank <= '0;
            st_q.ref_age  <= '1;
            st_q.mrs_age  <= '1;
            st_q.srx_age  <= '1;
            st_q.wr_age   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_age_o  = st_q.act_age;
    assign act_bank_o = st_q.act_bank;
    assign ref_age_o  = st_q.ref_age;
    assign mrs_age_o  = st_q.mrs_age;
    assign srx_age_o  = st_q.srx_age;
    assign wr_age_o   = st_q.wr_age;

endmodule

// File: rtl/dram_mon_rules.sv
module dram_mon_rules
    import dram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int CNT_W     = 16,
    parameter int T_RC      = 15,
    parameter int T_RFC     = 17,
    parameter int T_RAS     = 10,
    parameter int T_RCD_RD  = 5,
    parameter int T_RCD_WR  = 3,
    parameter int T_RP      = 5,
    parameter int T_RRD     = 4,
    parameter int T_DAL     = 10,
    parameter int T_CDLR    = 2,
    parameter int T_MRD     = 2,
    parameter int T_XSR     = 200,
    parameter int BURST_CLK = 2
) (
    input  logic                            cmd_valid_i,
    input  dram_cmd_e                       cmd_i,
    input  logic [BANK_W-1:0]               bank_i,
    input  logic [NUM_BANKS-1:0]            active_i,
    input  logic [NUM_BANKS-1:0]            ap_pend_i,
    input  logic [NUM_BANKS-1:0]            ras_over_i,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] act_age_i,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] pre_age_i,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] wr_age_i,
    input  logic [CNT_W-1:0]                dev_act_age_i,
    input  logic [BANK_W-1:0]               dev_act_bank_i,
    input  logic [CNT_W-1:0]                dev_ref_age_i,
    input  logic [CNT_W-1:0]                dev_mrs_age_i,
    input  logic [CNT_W-1:0]                dev_srx_age_i,
    input  logic [CNT_W-1:0]                dev_wr_age_i,
    output logic [NUM_RULES-1:0]            viol_o
);

    localparam logic [CNT_W-1:0] LIM_RC     = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] LIM_RFC    = CNT_W'(T_RFC);
    localparam logic [CNT_W-1:0] LIM_RAS    = CNT_W'(T_RAS);
    localparam logic [CNT_W-1:0] LIM_RCD_RD = CNT_W'(T_RCD_RD);
    localparam logic [CNT_W-1:0] LIM_RCD_WR = CNT_W'(T_RCD_WR);
    localparam logic [CNT_W-1:0] LIM_RP     = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] LIM_RRD    = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0] LIM_DAL    = CNT_W'(BURST_CLK + T_DAL);
    localparam logic [CNT_W-1:0] LIM_CDLR   = CNT_W'(BURST_CLK + T_CDLR);
    localparam logic [CNT_W-1:0] LIM_MRD    = CNT_W'(T_MRD);
    localparam logic [CNT_W-1:0] LIM_XSR    = CNT_W'(T_XSR);

    logic is_act, is_rd, is_wr_any, is_pre, is_ref;
    logic             b_active, b_ap;
    logic [CNT_W-1:0] b_act_age, b_pre_age, b_wr_age;

    always_comb begin
        is_act    = cmd_valid_i && (cmd_i == CMD_ACT);
        is_rd     = cmd_valid_i && (cmd_i == CMD_RD);
        is_wr_any = cmd_valid_i && ((cmd_i == CMD_WR) || (cmd_i == CMD_WRA));
        is_pre    = cmd_valid_i && (cmd_i == CMD_PRE);
        is_ref    = cmd_valid_i && (cmd_i == CMD_REF);

        b_active  = active_i[bank_i];
        b_ap      = ap_pend_i[bank_i];
        b_act_age = act_age_i[bank_i];
        b_pre_age = pre_age_i[bank_i];
        b_wr_age  = wr_age_i[bank_i];

        viol_o = '0;
        viol_o[RULE_STATE]   = ((is_rd || is_wr_any) && !b_active)
                               || (is_act && b_active)
                               || (is_ref && (|active_i));
        viol_o[RULE_RRD]     = is_act && (bank_i != dev_act_bank_i)
                               && (dev_act_age_i < LIM_RRD);
        viol_o[RULE_RC]      = is_act && (b_act_age < LIM_RC);
        viol_o[RULE_RP]      = is_act && (b_pre_age < LIM_RP);
        viol_o[RULE_RCD]     = b_active
                               && ((is_rd && (b_act_age < LIM_RCD_RD))
                                   || (is_wr_any && (b_act_age < LIM_RCD_WR)));
        viol_o[RULE_RAS_MIN] = is_pre && b_active && (b_act_age < LIM_RAS);
        viol_o[RULE_RAS_MAX] = |ras_over_i;
        viol_o[RULE_DAL]     = is_act && b_ap && (b_wr_age < LIM_DAL);
        viol_o[RULE_CDLR]    = is_rd && (dev_wr_age_i < LIM_CDLR);
        viol_o[RULE_RFC]     = cmd_valid_i && (dev_ref_age_i < LIM_RFC);
        viol_o[RULE_MRD]     = cmd_valid_i && (dev_mrs_age_i < LIM_MRD);
        viol_o[RULE_XSR]     = is_rd && (dev_srx_age_i < LIM_XSR);
    end

endmodule

// File: rtl/dram_cmd_timing_mon.sv
module dram_cmd_timing_mon
    import dram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RC      = 15,
    parameter int T_RFC     = 17,
    parameter int T_RAS     = 10,
    parameter int T_RCD_RD  = 5,
    parameter int T_RP      = 5,
    parameter int T_RRD     = 4,
    parameter int T_CDLR    = 2,
    parameter int T_MRD     = 2,
    parameter int T_XSR     = 200,
    parameter int T_RAS_MAX = 34966,
    parameter int BURST_CLK = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          cmd_valid_i,
    input  logic [2:0]                    cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0]  bank_i,
    input  logic [NUM_RULES-1:0]          clr_i,
    output logic [NUM_RULES-1:0]          viol_o,
    output logic                          viol_any_o,
    output logic [RULE_W-1:0]             viol_code_o,
    output logic [NUM_RULES-1:0]          sticky_o
);

    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int T_RCD_WR = (T_RCD_RD - 2 < 2) ? 2 : T_RCD_RD - 2;
    localparam int T_DAL    = T_WR_AUTO + T_RP;
    localparam int T_LONG   = max_int(max_int(T_RAS_MAX, T_XSR),
                                      max_int(max_int(T_RC, T_RFC),
                                              BURST_CLK + max_int(T_DAL, T_CDLR)));
    localparam int CNT_W    = $clog2(T_LONG + 2);

    typedef struct packed {
        logic [NUM_RULES-1:0] viol;
        logic                 any;
        logic [RULE_W-1:0]    code;
        logic [NUM_RULES-1:0] sticky;
    } out_st_t;

    out_st_t st_d, st_q;

    dram_cmd_e cmd;
    assign cmd = dram_cmd_e'(cmd_i);

    logic [NUM_BANKS-1:0]            bk_active, bk_ap, bk_ras_over;
    logic [NUM_BANKS-1:0][CNT_W-1:0] bk_act_age, bk_pre_age, bk_wr_age;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        dram_mon_bank #(
            .CNT_W     (CNT_W),
            .T_RAS_MAX (T_RAS_MAX)
        ) i_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .hit_i      (cmd_valid_i && (bank_i == BANK_W'(g))),
            .cmd_i      (cmd),
            .active_o   (bk_active[g]),
            .ap_pend_o  (bk_ap[g]),
            .act_age_o  (bk_act_age[g]),
            .pre_age_o  (bk_pre_age[g]),
            .wr_age_o   (bk_wr_age[g]),
            .ras_over_o (bk_ras_over[g])
        );
    end

    logic [CNT_W-1:0]  dv_act_age, dv_ref_age, dv_mrs_age, dv_srx_age, dv_wr_age;
    logic [BANK_W-1:0] dv_act_bank;

    dram_mon_dev #(
        .CNT_W  (CNT_W),
        .BANK_W (BANK_W)
    ) i_dev (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd),
        .bank_i      (bank_i),
        .act_age_o   (dv_act_age),
        .act_bank_o  (dv_act_bank),
        .ref_age_o   (dv_ref_age),
        .mrs_age_o   (dv_mrs_age),
        .srx_age_o   (dv_srx_age),
        .wr_age_o    (dv_wr_age)
    );

    logic [NUM_RULES-1:0] hit_vec;

    dram_mon_rules #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .CNT_W     (CNT_W),
        .T_RC      (T_RC),
        .T_RFC     (T_RFC),
        .T_RAS     (T_RAS),
        .T_RCD_RD  (T_RCD_RD),
        .T_RCD_WR  (T_RCD_WR),
        .T_RP      (T_RP),
        .T_RRD     (T_RRD),
        .T_DAL     (T_DAL),
        .T_CDLR    (T_CDLR),
        .T_MRD     (T_MRD),
        .T_XSR     (T_XSR),
        .BURST_CLK (BURST_CLK)
    ) i_rules (
        .cmd_valid_i    (cmd_valid_i),
        .cmd_i          (cmd),
        .bank_i         (bank_i),
        .active_i       (bk_active),
        .ap_pend_i      (bk_ap),
        .ras_over_i     (bk_ras_over),
        .act_age_i      (bk_act_age),
        .pre_age_i      (bk_pre_age),
        .wr_age_i       (bk_wr_age),
        .dev_act_age_i  (dv_act_age),
        .dev_act_bank_i (dv_act_bank),
        .dev_ref_age_i  (dv_ref_age),
        .dev_mrs_age_i  (dv_mrs_age),
        .dev_srx_age_i  (dv_srx_age),
        .dev_wr_age_i   (dv_wr_age),
        .viol_o         (hit_vec)
    );

    always_comb begin
        st_d        = st_q;
        st_d.viol   = hit_vec;
        st_d.any    = |hit_vec;
        st_d.code   = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                st_d.code = RULE_W'(i);
            end
        end
        st_d.sticky = (st_q.sticky & ~clr_i) | hit_vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_o      = st_q.viol;
    assign viol_any_o  = st_q.any;
    assign viol_code_o = st_q.code;
    assign sticky_o    = st_q.sticky;

endmodule

// File: rtl/dram_cmd_timing_mon_chk.sv
module dram_cmd_timing_mon_chk
    import dram_mon_pkg::*;
#(
    parameter int T_RFC = 17,
    parameter int T_MRD = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 cmd_valid_i,
    input logic [2:0]           cmd_i,
    input logic [NUM_RULES-1:0] clr_i,
    input logic [NUM_RULES-1:0] viol_o,
    input logic                 viol_any_o,
    input logic [RULE_W-1:0]    viol_code_o,
    input logic [NUM_RULES-1:0] sticky_o
);

    localparam logic [NUM_RULES-1:0] QUIET_MASK = ~(NUM_RULES'(1) << RULE_RAS_MAX);

    logic [7:0] ref_age, mrs_age;
    logic [NUM_RULES-1:0] below_code;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_age <= 8'hFF;
            mrs_age <= 8'hFF;
        end else begin
            ref_age <= (cmd_valid_i && cmd_i == 3'd5) ? 8'd1
                     : ((ref_age == 8'hFF) ? ref_age : ref_age + 8'd1);
            mrs_age <= (cmd_valid_i && cmd_i == 3'd6) ? 8'd1
                     : ((mrs_age == 8'hFF) ? mrs_age : mrs_age + 8'd1);
        end
    end

    assign below_code = (NUM_RULES'(1) << viol_code_o) - NUM_RULES'(1);

    // R10
    rfc_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && (32'(ref_age) < T_RFC)) |=> viol_o[RULE_RFC]);

    // R10
    mrd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && (32'(mrs_age) < T_MRD)) |=> viol_o[RULE_MRD]);

    // R12
    code_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_any_o |-> (viol_o[viol_code_o] && ((viol_o & below_code) == '0)));

    // R12
    idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !viol_any_o |-> ((viol_code_o == '0) && (viol_o == '0)));

    // R12
    quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_valid_i |=> ((viol_o & QUIET_MASK) == '0));

    // R13
    sticky_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (viol_o & ~sticky_o) == '0);

    // R13
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(sticky_o) & ~$past(clr_i) & ~sticky_o) == '0));

endmodule

bind dram_cmd_timing_mon dram_cmd_timing_mon_chk #(
    .T_RFC (T_RFC),
    .T_MRD (T_MRD)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .clr_i       (clr_i),
    .viol_o      (viol_o),
    .viol_any_o  (viol_any_o),
    .viol_code_o (viol_code_o),
    .sticky_o    (sticky_o)
);

// File: tb/test_dram_cmd_timing_mon.sv
module test_dram_cmd_timing_mon;

    localparam int NB = 4;
    localparam int TB_RC = 15, TB_RFC = 17, TB_RAS = 10, TB_RCD_RD = 5, TB_RCD_WR = 3;
    localparam int TB_RP = 5, TB_RRD = 4, TB_DAL = 10, TB_CDLR = 2, TB_MRD = 2;
    localparam int TB_XSR = 200, TB_RAS_MAX = 60, TB_BURST = 2;
    localparam int C_ACT = 0, C_RD = 1, C_WR = 2, C_PRE = 3, C_WRA = 4, C_REF = 5, C_MRS = 6, C_SRX = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  bank = 2'd0;
    logic [11:0] clr = '0;
    logic [11:0] viol, sticky;
    logic        viol_any;
    logic [3:0]  viol_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R14";

    // behavioural model state: times of last events
    int t = 0;
    int m_act[NB], m_pre[NB], m_wr[NB];
    bit m_open[NB], m_ap[NB];
    int g_act = -100000, g_actb = 0, g_ref = -100000, g_mrs = -100000;
    int g_srx = -100000, g_wr = -100000;
    logic [11:0] exp_viol = '0, exp_sticky = '0;

    always #5 clk = ~clk;

    dram_cmd_timing_mon #(.T_RAS_MAX(TB_RAS_MAX)) i_dram_cmd_timing_mon (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .bank_i      (bank),
        .clr_i       (clr),
        .viol_o      (viol),
        .viol_any_o  (viol_any),
        .viol_code_o (viol_code),
        .sticky_o    (sticky)
    );

    function automatic logic [11:0] model_eval(bit v, int c, int b);
        logic [11:0] e = '0;
        bit any_open = 1'b0;
        for (int k = 0; k < NB; k++) any_open |= m_open[k];
        if (v) begin
            if (((c == C_RD) || (c == C_WR) || (c == C_WRA)) && !m_open[b]) e[0] = 1'b1;
            if ((c == C_ACT) && m_open[b]) e[0] = 1'b1;
            if ((c == C_REF) && any_open) e[0] = 1'b1;
            if ((c == C_ACT) && (b != g_actb) && (t - g_act < TB_RRD)) e[1] = 1'b1;
            if ((c == C_ACT) && (t - m_act[b] < TB_RC)) e[2] = 1'b1;
            if ((c == C_ACT) && (t - m_pre[b] < TB_RP)) e[3] = 1'b1;
            if (m_open[b] && (((c == C_RD) && (t - m_act[b] < TB_RCD_RD)) ||
                (((c == C_WR) || (c == C_WRA)) && (t - m_act[b] < TB_RCD_WR)))) e[4] = 1'b1;
            if ((c == C_PRE) && m_open[b] && (t - m_act[b] < TB_RAS)) e[5] = 1'b1;
            if ((c == C_ACT) && m_ap[b] && (t - m_wr[b] < TB_BURST + TB_DAL)) e[7] = 1'b1;
            if ((c == C_RD) && (t - g_wr < TB_BURST + TB_CDLR)) e[8] = 1'b1;
            if (t - g_ref < TB_RFC) e[9] = 1'b1;
            if (t - g_mrs < TB_MRD) e[10] = 1'b1;
            if ((c == C_RD) && (t - g_srx < TB_XSR)) e[11] = 1'b1;
        end
        for (int k = 0; k < NB; k++) begin
            if (m_open[k] && (t - m_act[k] == TB_RAS_MAX) &&
                !(v && (b == k) && ((c == C_PRE) || (c == C_WRA)))) e[6] = 1'b1;
        end
        return e;
    endfunction

    task automatic model_update(bit v, int c, int b);
        if (!v) return;
        case (c)
            C_ACT: begin m_open[b] = 1'b1; m_ap[b] = 1'b0; m_act[b] = t; g_act = t; g_actb = b; end
            C_PRE: if (m_open[b]) begin m_open[b] = 1'b0; m_pre[b] = t; end
            C_WR:  begin m_wr[b] = t; g_wr = t; end
            C_WRA: begin m_wr[b] = t; g_wr = t; m_open[b] = 1'b0; m_ap[b] = 1'b1; end
            C_REF: g_ref = t;
            C_MRS: g_mrs = t;
            C_SRX: g_srx = t;
            default: ;
        endcase
    endtask

    function automatic int low_code(logic [11:0] v);
        for (int i = 0; i < 12; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s at t=%0d: actual %0d expected %0d", req, what, t, act, expv);
        end
    endtask

    task automatic step(bit v, int c, int b, logic [11:0] clr_v);
        logic [11:0] ev;
        cmd_valid = v;
        cmd = 3'(c);
        bank = 2'(b);
        clr = clr_v;
        ev = model_eval(v, c, b);
        model_update(v, c, b);
        exp_viol = ev;
        exp_sticky = (exp_sticky & ~clr_v) | ev;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if ((viol !== exp_viol) || (sticky !== exp_sticky) || (viol_any !== (|exp_viol)) ||
            (viol_code !== 4'(low_code(exp_viol)))) begin
            errors++;
            $display("FAIL %s t=%0d: viol %h sticky %h any %b code %0d, expected %h %h %b %0d",
                     tag, t, viol, sticky, viol_any, viol_code,
                     exp_viol, exp_sticky, |exp_viol, low_code(exp_viol));
        end
        t++;
        cmd_valid = 1'b0;
        clr = '0;
    endtask

    task automatic issue(int c, int b);
        step(1'b1, c, b, '0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NB; k++) begin
            m_act[k] = -100000; m_pre[k] = -100000; m_wr[k] = -100000;
            m_open[k] = 1'b0; m_ap[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R14: reset state
        check("R14", int'(viol), 0, "viol after reset");
        check("R14", int'(sticky), 0, "sticky after reset");
        check("R14", int'(viol_any), 0, "any after reset");
        idle(2);

        // R1: read to a closed bank
        tag = "R1";
        issue(C_RD, 0);
        check("R1", int'(viol[0]), 1, "state bit");
        check("R12", int'(viol_code), 0, "code");
        idle(1);
        check("R12", int'(viol), 0, "pulse lasts one clock");

        // R5: read too soon after activate
        tag = "R5";
        issue(C_ACT, 0);
        idle(2);
        issue(C_RD, 0);
        check("R5", int'(viol[4]), 1, "read rcd bit");

        // R6: precharge before minimum active time
        tag = "R6";
        idle(1);
        issue(C_PRE, 0);
        check("R6", int'(viol[5]), 1, "ras min bit");

        // R3 and R4: reactivate too soon
        tag = "R3_R4";
        issue(C_ACT, 0);
        check("R3", int'(viol[2]), 1, "rc bit");
        check("R4", int'(viol[3]), 1, "rp bit");

        // R2: activate to another bank too soon
        tag = "R2";
        issue(C_ACT, 1);
        check("R2", int'(viol[1]), 1, "rrd bit");

        // R5: write exactly at derived delay is legal
        tag = "R5";
        idle(2);
        issue(C_WR, 1);
        check("R5", int'(viol_any), 0, "write at derived delay");

        // R9: read right after write
        tag = "R9";
        issue(C_RD, 1);
        check("R9", int'(viol[8]), 1, "cdlr bit");
        check("R12", int'(viol_code), 4, "lowest code wins");

        // R8: activate too soon after auto-precharge write
        tag = "R8";
        issue(C_WRA, 1);
        idle(3);
        issue(C_ACT, 1);
        check("R8", int'(viol[7]), 1, "dal bit");

        // R8: exact boundary on another bank is legal
        idle(4);
        issue(C_ACT, 2);
        idle(2);
        issue(C_WRA, 2);
        idle(11);
        issue(C_ACT, 2);
        check("R8", int'(viol[7]), 0, "dal boundary legal");

        // R7: rows left open too long
        tag = "R7";
        idle(70);
        check("R7", int'(sticky[6]), 1, "ras max sticky");
        issue(C_PRE, 0);
        issue(C_PRE, 1);
        issue(C_PRE, 2);

        // R13: clear all
        tag = "R13";
        step(1'b0, 0, 0, 12'hFFF);
        check("R13", int'(sticky), 0, "cleared");

        // R10: command inside refresh window
        tag = "R10";
        issue(C_REF, 0);
        idle(1);
        issue(C_ACT, 0);
        check("R10", int'(viol[9]), 1, "rfc bit");
        idle(20);
        issue(C_PRE, 0);
        issue(C_MRS, 0);
        tag = "R10_R13";
        step(1'b1, C_ACT, 3, 12'h400);
        check("R10", int'(viol[10]), 1, "mrd bit");
        check("R13", int'(sticky[10]), 1, "set wins over clear");

        // R11: read after self-refresh exit
        tag = "R11";
        issue(C_SRX, 0);
        idle(5);
        issue(C_RD, 3);
        check("R11", int'(viol[11]), 1, "xsr bit");
        idle(193);
        issue(C_RD, 3);
        check("R11", int'(viol[11]), 0, "xsr boundary legal");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule